// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix with Key Lock

This block takes event pulses on a bank of trigger inputs and spreads them over a few shared broadcast channels. From those channels it raises a bank of trigger outputs. Each input has a mask that selects the channels it drives. Each output has a mask that selects the channels it listens to. An output is captured in a sticky latch and holds until software acknowledges it. Software can also drive channels itself, either with a held level that it sets and clears or with a one-cycle pulse.

All programming goes through a simple single-cycle 32-bit register bus. A write is taken on the rising clock edge when `bus_wr` is high. Reads are combinational from `bus_addr`. A key-based lock protects every register except the key register itself. The unit leaves reset locked, so software must first write the key before any other write is accepted.

Top module: `xtrig_matrix`

## Requirements
- R1: A write of 0xC5ACCE55 to offset 0xFB0 unlocks the unit, and a write of any other value to 0xFB0 locks it. Writes to 0xFB0 are accepted in either state.
- R2: Bit 0 read at offset 0xFB4 is 1 while locked and 0 while unlocked. All other bits of that register read 0.
- R3: While the unit is locked, writes to every offset other than 0xFB0 have no effect. This covers control, masks, acknowledge and the application registers.
- R4: Bit 0 of the control register at 0x000 is the global enable. While it is 0, no trigger output becomes newly set.
- R5: Bit c of the input mask at 0x020+4*n routes trigger input n to channel c. Offset 0x138 reads the channels driven by inputs alone, in bits [3:0].
- R6: Bit c of the output mask at 0x0A0+4*m lets channel c set trigger output m. The output rises on the clock edge after the clock edge at which its channel is active.
- R7: Writing 1s to 0x014 sets held application channel bits, which read back at 0x014. Writing 1s to 0x018 clears them. Writing 1s to 0x01C activates those channels for exactly one cycle, the cycle after the write edge.
- R8: A set trigger output stays set until bit m is written as 1 to the acknowledge register at 0x010. If an output's channel is active in the same cycle as its acknowledge, the output stays set.
- R9: Offset 0x130 reads the raw trigger inputs, 0x134 reads the latched trigger outputs, and 0x13C reads all channel activity (inputs, held bits and pulse bits).
- R10: After reset, the unit is locked and disabled, all masks are zero and all outputs are low. Unmapped offsets read zero. Mask bits above the channel count are dropped on write and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| trig_in | input | 8 | Trigger input events |
| trig_out | output | 8 | Latched trigger outputs |

## Verification
A fixed routing setup is driven in three ways. Single inputs isolate each channel. Input 4 maps to two channels, which exposes a wrong OR across channels. Inputs with empty masks must raise nothing, and combined patterns check that several channels merge onto shared outputs. The held and one-shot application bits drive the same outputs without any input, which separates the software paths from the input path. Directed cases check that the lock blocks every write, including an acknowledge, and that a trigger held through an acknowledge keeps its output set.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int          ADDR_W     = 12;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_ACK   = 12'h010;
  localparam logic [ADDR_W-1:0] A_ASET  = 12'h014;
  localparam logic [ADDR_W-1:0] A_ACLR  = 12'h018;
  localparam logic [ADDR_W-1:0] A_APUL  = 12'h01C;
  localparam logic [ADDR_W-1:0] A_INEN  = 12'h020;
  localparam logic [ADDR_W-1:0] A_OUTEN = 12'h0A0;
  localparam logic [ADDR_W-1:0] A_TIN   = 12'h130;
  localparam logic [ADDR_W-1:0] A_TOUT  = 12'h134;
  localparam logic [ADDR_W-1:0] A_CHIN  = 12'h138;
  localparam logic [ADDR_W-1:0] A_CHOUT = 12'h13C;
  localparam logic [ADDR_W-1:0] A_LKEY  = 12'hFB0;
  localparam logic [ADDR_W-1:0] A_LSTAT = 12'hFB4;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base, input int idx);
    return base + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [N_IN-1:0]           trig_in,
  input  logic [N_OUT-1:0]          trig_out,
  input  logic [N_CH-1:0]           ch_in,
  input  logic [N_CH-1:0]           ch_all,
  output logic                      enable,
  output logic [N_IN-1:0][N_CH-1:0] in_en,
  output logic [N_OUT-1:0][N_CH-1:0] out_en,
  output logic [N_CH-1:0]           app_set,
  output logic [N_CH-1:0]           app_pulse,
  output logic [N_OUT-1:0]          ack_mask,
  output logic                      locked
);
  logic wr_ok;
  assign wr_ok    = bus_wr && !locked;
  assign ack_mask = (wr_ok && bus_addr == A_ACK) ? bus_wdata[N_OUT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      enable    <= 1'b0;
      app_set   <= '0;
      app_pulse <= '0;
    end else begin
      app_pulse <= '0;
      if (bus_wr && bus_addr == A_LKEY) locked <= (bus_wdata != UNLOCK_KEY);
      if (wr_ok) begin
        case (bus_addr)
          A_CTRL:  enable    <= bus_wdata[0];
          A_ASET:  app_set   <= app_set | bus_wdata[N_CH-1:0];
          A_ACLR:  app_set   <= app_set & ~bus_wdata[N_CH-1:0];
          A_APUL:  app_pulse <= bus_wdata[N_CH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < N_IN; n++) begin : g_inmask
    always_ff @(posedge clk) begin
      if (!rst_n) in_en[n] <= '0;
      else if (wr_ok && bus_addr == slot_addr(A_INEN, n)) in_en[n] <= bus_wdata[N_CH-1:0];
    end
  end

  for (genvar m = 0; m < N_OUT; m++) begin : g_outmask
    always_ff @(posedge clk) begin
      if (!rst_n) out_en[m] <= '0;
      else if (wr_ok && bus_addr == slot_addr(A_OUTEN, m)) out_en[m] <= bus_wdata[N_CH-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[0]         = enable;
      A_ASET:  bus_rdata[N_CH-1:0]  = app_set;
      A_TIN:   bus_rdata[N_IN-1:0]  = trig_in;
      A_TOUT:  bus_rdata[N_OUT-1:0] = trig_out;
      A_CHIN:  bus_rdata[N_CH-1:0]  = ch_in;
      A_CHOUT: bus_rdata[N_CH-1:0]  = ch_all;
      A_LSTAT: bus_rdata[0]         = locked;
      default: ;
    endcase
    for (int n = 0; n < N_IN; n++)
      if (bus_addr == slot_addr(A_INEN, n)) bus_rdata[N_CH-1:0] = in_en[n];
    for (int m = 0; m < N_OUT; m++)
      if (bus_addr == slot_addr(A_OUTEN, m)) bus_rdata[N_CH-1:0] = out_en[m];
  end
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic                       enable,
  input  logic [N_IN-1:0]            trig_in,
  input  logic [N_IN-1:0][N_CH-1:0]  in_en,
  input  logic [N_OUT-1:0][N_CH-1:0] out_en,
  input  logic [N_CH-1:0]            app_set,
  input  logic [N_CH-1:0]            app_pulse,
  output logic [N_CH-1:0]            ch_in,
  output logic [N_CH-1:0]            ch_all,
  output logic [N_OUT-1:0]           hits
);
  function automatic logic [N_CH-1:0] gather(input logic [N_IN-1:0] t,
                                             input logic [N_IN-1:0][N_CH-1:0] msk);
    logic [N_CH-1:0] acc = '0;
    for (int n = 0; n < N_IN; n++)
      if (t[n]) acc |= msk[n];
    return acc;
  endfunction

  assign ch_in  = gather(trig_in, in_en);
  assign ch_all = ch_in | app_set | app_pulse;

  for (genvar m = 0; m < N_OUT; m++) begin : g_hit
    assign hits[m] = enable && |(ch_all & out_en[m]);
  end
endmodule

// File: rtl/xtrig_latch.sv
module xtrig_latch #(
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] hits,
  input  logic [N_OUT-1:0] ack_mask,
  output logic [N_OUT-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= (out_q & ~ack_mask) | hits;
  end
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_IN-1:0]   trig_in,
  output logic [N_OUT-1:0]  trig_out
);
  logic                       enable;
  logic                       locked;
  logic [N_IN-1:0][N_CH-1:0]  in_en;
  logic [N_OUT-1:0][N_CH-1:0] out_en;
  logic [N_CH-1:0]            app_set;
  logic [N_CH-1:0]            app_pulse;
  logic [N_CH-1:0]            ch_in;
  logic [N_CH-1:0]            ch_all;
  logic [N_OUT-1:0]           hits;
  logic [N_OUT-1:0]           ack_mask;

  xtrig_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .trig_out(trig_out), .ch_in(ch_in), .ch_all(ch_all), .enable(enable),
    .in_en(in_en), .out_en(out_en), .app_set(app_set), .app_pulse(app_pulse),
    .ack_mask(ack_mask), .locked(locked)
  );

  xtrig_route #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_route (
    .enable(enable), .trig_in(trig_in), .in_en(in_en), .out_en(out_en),
    .app_set(app_set), .app_pulse(app_pulse), .ch_in(ch_in),
    .ch_all(ch_all), .hits(hits)
  );

  xtrig_latch #(.N_OUT(N_OUT)) u_latch (
    .clk(clk), .rst_n(rst_n), .hits(hits), .ack_mask(ack_mask), .out_q(trig_out)
  );
endmodule

// File: rtl/xtrig_checker.sv
module xtrig_checker
  import xtrig_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_OUT-1:0]  trig_out,
  input logic              locked,
  input logic              enable,
  input logic [N_CH-1:0]   app_pulse,
  input logic [N_OUT-1:0]  ack_mask
);
  p_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LKEY && bus_wdata == UNLOCK_KEY) |=> !locked);

  p_relock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LKEY && bus_wdata != UNLOCK_KEY) |=> locked);

  p_locked_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && bus_addr == A_CTRL) |=> $stable(enable));

  p_locked_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ack_mask == '0));

  p_disabled_no_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((trig_out & ~$past(trig_out)) == '0));

  p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((app_pulse != '0) && !(bus_wr && bus_addr == A_APUL)) |=> (app_pulse == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask == '0) |=> ((trig_out & $past(trig_out)) == $past(trig_out)));
endmodule

bind xtrig_matrix xtrig_checker #(.N_OUT(N_OUT), .N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .trig_out(trig_out), .locked(locked),
  .enable(enable), .app_pulse(app_pulse), .ack_mask(ack_mask)
);

// File: tb/test_xtrig_matrix.sv
module test_xtrig_matrix;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  trig_in = '0;
  logic [7:0]  trig_out;

  int applied = 0;
  int bad = 0;

  xtrig_matrix i_xtrig_matrix (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .trig_out(trig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {trig_in, channels from inputs, expected trig_out}
  localparam logic [19:0] VECS [9] = '{
    {8'h01, 4'h1, 8'h51}, {8'h02, 4'h2, 8'h52}, {8'h04, 4'h4, 8'h64},
    {8'h08, 4'h8, 8'h68}, {8'h10, 4'h3, 8'h53}, {8'hE0, 4'h0, 8'h00},
    {8'h05, 4'h5, 8'h75}, {8'hFF, 4'hF, 8'h7F}, {8'h00, 4'h0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 trig_out after reset", {24'h0, trig_out}, 32'h0);
    rd(12'hFB4, d); chk("R2 R10 locked after reset", d, 32'h1);
    rd(12'h000, d); chk("R10 disabled after reset", d, 32'h0);
    rd(12'h020, d); chk("R10 input mask zero", d, 32'h0);
    rd(12'h200, d); chk("R10 unmapped read", d, 32'h0);
    trig_in = 8'hA5;
    rd(12'h130, d); chk("R9 raw input status", d, 32'hA5);
    trig_in = 8'h00;

    // R3 writes ignored while locked
    wr(12'h000, 32'h1);
    rd(12'h000, d); chk("R3 ctrl write while locked", d, 32'h0);
    wr(12'h020, 32'hF);
    rd(12'h020, d); chk("R3 mask write while locked", d, 32'h0);

    // R1 R2 unlock
    wr(12'hFB0, 32'hC5ACCE55);
    rd(12'hFB4, d); chk("R1 R2 unlocked status", d, 32'h0);

    // R10 unused mask bits
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, d); chk("R10 unused mask bits", d, 32'hF);

    // routing setup (R5 R6)
    wr(12'h020, 32'h1); wr(12'h024, 32'h2); wr(12'h028, 32'h4);
    wr(12'h02C, 32'h8); wr(12'h030, 32'h3);
    wr(12'h0A0, 32'h1); wr(12'h0A4, 32'h2); wr(12'h0A8, 32'h4);
    wr(12'h0AC, 32'h8); wr(12'h0B0, 32'h3); wr(12'h0B4, 32'hC);
    wr(12'h0B8, 32'hF);
    rd(12'h0B4, d); chk("R6 output mask readback", d, 32'hC);
    wr(12'h000, 32'h1);
    rd(12'h000, d); chk("R4 enable readback", d, 32'h1);

    for (int i = 0; i < 9; i++) begin
      trig_in = VECS[i][19:12];
      rd(12'h138, d); chk("R5 channel-in status", d, {28'h0, VECS[i][11:8]});
      @(negedge clk);
      trig_in = 8'h00;
      chk("R6 routed output", {24'h0, trig_out}, {24'h0, VECS[i][7:0]});
      wr(12'h010, 32'hFF);
      chk("R8 acknowledge clears", {24'h0, trig_out}, 32'h0);
    end

    // R4 disabled blocks new outputs
    wr(12'h000, 32'h0);
    trig_in = 8'h01;
    @(negedge clk);
    trig_in = 8'h00;
    @(negedge clk);
    chk("R4 disabled no output", {24'h0, trig_out}, 32'h0);
    wr(12'h000, 32'h1);

    // R7 held application channel
    wr(12'h014, 32'h1);
    @(negedge clk);
    chk("R7 app set drives output", {24'h0, trig_out}, 32'h51);
    rd(12'h014, d); chk("R7 app set readback", d, 32'h1);
    wr(12'h018, 32'h1);
    wr(12'h010, 32'hFF);
    chk("R7 app clear then ack", {24'h0, trig_out}, 32'h0);
    rd(12'h13C, d); chk("R9 R7 channel status after clear", d, 32'h0);

    // R7 one-cycle pulse
    wr(12'h01C, 32'h2);
    rd(12'h13C, d); chk("R7 R9 pulse visible", d, 32'h2);
    @(negedge clk);
    chk("R7 pulse drives output", {24'h0, trig_out}, 32'h52);
    rd(12'h13C, d); chk("R7 pulse self-clears", d, 32'h0);
    wr(12'h010, 32'hFF);
    chk("R7 no output after pulse ack", {24'h0, trig_out}, 32'h0);

    // R8 trigger beats simultaneous acknowledge
    trig_in = 8'h01;
    wr(12'h010, 32'hFF);
    chk("R8 trigger wins over ack", {24'h0, trig_out}, 32'h51);
    trig_in = 8'h00;
    wr(12'h010, 32'hFF);
    chk("R8 ack after trigger gone", {24'h0, trig_out}, 32'h0);

    // R8 sticky output
    trig_in = 8'h04;
    @(negedge clk);
    trig_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 output stays set", {24'h0, trig_out}, 32'h64);
    rd(12'h134, d); chk("R9 output status", d, 32'h64);

    // R1 relock with wrong key, R3 ack and ctrl ignored
    wr(12'hFB0, 32'h0);
    rd(12'hFB4, d); chk("R1 R2 relocked status", d, 32'h1);
    wr(12'h010, 32'hFF);
    chk("R3 ack ignored while locked", {24'h0, trig_out}, 32'h64);
    wr(12'h000, 32'h0);
    rd(12'h000, d); chk("R3 disable ignored while locked", d, 32'h1);

    finish_run();
  end
endmodule